// File: doc/BRIEF.md
# Linked-List Realtime Thread Scheduler

This block holds a fixed table of thread descriptors and hands runnable threads to idle cores. Each slot of the table stores a process ID, thread ID, context pointer, deadline threshold, the number of the core it was handed to, an occupancy state and link indices. The slots are chained into three lists: free slots, normal waiting threads and urgent waiting threads. A producer posts a thread on the enqueue port, an idle core asks for work on the dispatch port and gets a descriptor one cycle later, and a core that has finished its thread names itself on the completion port so its slot returns to the pool.

Urgent threads skip the normal queue entirely. A free-running cycle counter is compared, one slot per cycle, against the threshold of waiting normal threads. A thread whose deadline has been reached is lifted into the urgent queue, so late work overtakes ordinary work without software involvement.

Top module: `rtsched_top`

## Requirements
- R1: During and directly after a synchronous active-high reset, all 16 slots are free (enq_ready is 1), both run lists are empty, cycle_now is 0 and the promotion scan index is 0.
- R2: When enq_valid and enq_ready are both 1 at a clock edge, the slot at the head of the free list is taken, filled with the posted fields and appended to the tail of the urgent list (enq_urgent = 1) or the normal list (enq_urgent = 0). After reset the free list holds slots in ascending index order 0, 1, ..., 15.
- R3: enq_ready is 0 exactly when no slot is free; an enq_valid pulse while enq_ready is 0 changes nothing.
- R4: A dispatch request (disp_req = 1 at an edge) is answered at the following edge: disp_valid is 1 for one cycle and, when work was found, disp_slot, disp_pid, disp_tid and disp_ctx carry the granted slot and its stored fields.
- R5: Dispatch takes the head of the urgent list whenever that list is non-empty and the head of the normal list only otherwise; each list is served in first-in, first-out order.
- R6: A dispatch request while both run lists are empty is answered with disp_valid = 1 and disp_found = 0.
- R7: The scan index equals the number of cycles since reset modulo 16. In each cycle the slot it points at, if it is waiting on the normal list and its threshold is less than or equal to cycle_now, is unlinked from the normal list and appended to the urgent tail.
- R8: A completion (done_valid = 1) names a core; the lowest-index running slot recorded for that core becomes free and is pushed onto the head of the free list, so the next enqueue reuses it. A completion naming a core with no running slot has no effect.
- R9: A granted slot records the core number given on disp_core in the same cycle as the request.
- R10: cycle_now increments by one on every clock edge outside reset and wraps at its width.
- R11: Within one cycle the operations act in the order completion, dispatch, enqueue, promotion, each seeing the lists as left by the one before; enq_ready is taken from the free list as it stood at the start of the cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Thread posting request |
| enq_ready | output | 1 | A free slot is available |
| enq_pid | input | 8 | Process ID of posted thread |
| enq_tid | input | 8 | Thread ID of posted thread |
| enq_ctx | input | 16 | Context pointer of posted thread |
| enq_thresh | input | 16 | Deadline threshold in cycles |
| enq_urgent | input | 1 | Post directly to the urgent list |
| disp_req | input | 1 | Idle core asks for work |
| disp_core | input | 3 | Number of the requesting core |
| disp_valid | output | 1 | Dispatch answer present |
| disp_found | output | 1 | Answer carries a thread |
| disp_slot | output | 4 | Granted slot index |
| disp_pid | output | 8 | Process ID of granted thread |
| disp_tid | output | 8 | Thread ID of granted thread |
| disp_ctx | output | 16 | Context pointer of granted thread |
| done_valid | input | 1 | A core has finished its thread |
| done_core | input | 3 | Number of the finishing core |
| cycle_now | output | 16 | Free-running cycle counter |

## Verification
enq_ready and cycle_now are read from registers, so they reflect every operation of the previous edge and are due in the very next cycle, while a dispatch answer appears exactly one edge after its request. The bench drives all inputs and samples all outputs at the falling edge: at each falling edge it first compares the outputs against the reference queues as they were left by the last edge, then applies new stimulus and advances the reference by one cycle in the R11 order, storing the dispatch answer it expects at the next falling edge. Promotion is predicted from the cycle_now value and the scan position of the same cycle, so the reference moves a thread to the urgent list in the same cycle the hardware does.

// File: rtl/rtsched_pkg.sv
package rtsched_pkg;

    localparam int PID_W  = 8;
    localparam int TID_W  = 8;
    localparam int CTX_W  = 16;
    localparam int TIME_W = 16;
    localparam int CORE_W = 3;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_NORM = 2'd1,
        SLOT_HIGH = 2'd2,
        SLOT_RUN  = 2'd3
    } slot_state_e;

    typedef struct packed {
        logic [PID_W-1:0]  pid;
        logic [TID_W-1:0]  tid;
        logic [CTX_W-1:0]  ctx;
        logic [TIME_W-1:0] thresh;
    } thread_desc_t;

    function automatic logic deadline_hit(input logic [TIME_W-1:0] thresh,
                                          input logic [TIME_W-1:0] now);
        return thresh <= now;
    endfunction

endpackage

// File: rtl/rtsched_timebase.sv
module rtsched_timebase
    import rtsched_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic [TIME_W-1:0]      now,
    output logic [$clog2(SLOTS)-1:0] scan
);
    localparam int IW = $clog2(SLOTS);

    logic [TIME_W-1:0] now_q;
    logic [IW-1:0]     scan_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= '0;
            scan_q <= '0;
        end else begin
            now_q  <= now_q + 1'b1;
            scan_q <= (scan_q == IW'(SLOTS - 1)) ? '0 : scan_q + 1'b1;
        end
    end

    assign now  = now_q;
    assign scan = scan_q;

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> now_q == $past(now_q) + 1'b1); // R10

endmodule

// File: rtl/rtsched_core_match.sv
module rtsched_core_match
    import rtsched_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic [SLOTS-1:0]             run_mask,
    input  logic [SLOTS-1:0][CORE_W-1:0] core_tags,
    input  logic                         done_valid,
    input  logic [CORE_W-1:0]            done_core,
    output logic                         hit,
    output logic [$clog2(SLOTS)-1:0]     hit_slot
);
    localparam int IW = $clog2(SLOTS);

    logic [SLOTS-1:0] match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign match[g] = done_valid && run_mask[g] && (core_tags[g] == done_core);
    end

    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit      = 1'b1;
                hit_slot = IW'(i);
            end
        end
    end

endmodule

// File: rtl/rtsched_list_table.sv
module rtsched_list_table
    import rtsched_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [TIME_W-1:0]            now,
    input  logic [$clog2(SLOTS)-1:0]     scan,
    input  logic                         done_hit,
    input  logic [$clog2(SLOTS)-1:0]     done_slot,
    input  logic                         enq_valid,
    input  logic                         enq_urgent,
    input  thread_desc_t                 enq_desc,
    output logic                         enq_ready,
    input  logic                         disp_req,
    input  logic [CORE_W-1:0]            disp_core,
    output logic [SLOTS-1:0]             run_mask,
    output logic [SLOTS-1:0][CORE_W-1:0] core_tags,
    output logic                         rsp_valid,
    output logic                         rsp_found,
    output logic [$clog2(SLOTS)-1:0]     rsp_slot,
    output thread_desc_t                 rsp_desc
);
    localparam int IW = $clog2(SLOTS);
    localparam int PW = IW + 1;
    localparam logic [PW-1:0] NIL = {1'b1, {IW{1'b0}}};

    slot_state_e       st_q   [SLOTS];
    slot_state_e       st_n   [SLOTS];
    logic [PW-1:0]     nx_q   [SLOTS];
    logic [PW-1:0]     nx_n   [SLOTS];
    logic [PW-1:0]     pv_q   [SLOTS];
    logic [PW-1:0]     pv_n   [SLOTS];
    thread_desc_t      desc_q [SLOTS];
    thread_desc_t      desc_n [SLOTS];
    logic [CORE_W-1:0] core_q [SLOTS];
    logic [CORE_W-1:0] core_n [SLOTS];

    logic [PW-1:0] free_h, norm_h, norm_t, high_h, high_t;
    logic [PW-1:0] free_hn, norm_hn, norm_tn, high_hn, high_tn;
    logic [PW-1:0] lnk_p, lnk_q;
    logic [IW-1:0] grab, pop_e;
    logic          found, enq_fire;

    function automatic logic [IW-1:0] ix(input logic [PW-1:0] p);
        return p[IW-1:0];
    endfunction

    assign enq_ready = !free_h[IW];
    assign enq_fire  = enq_valid && !free_h[IW];

    always_comb begin
        st_n    = st_q;
        nx_n    = nx_q;
        pv_n    = pv_q;
        desc_n  = desc_q;
        core_n  = core_q;
        free_hn = free_h;
        norm_hn = norm_h;
        norm_tn = norm_t;
        high_hn = high_h;
        high_tn = high_t;
        found   = 1'b0;
        grab    = '0;
        pop_e   = '0;
        lnk_p   = NIL;
        lnk_q   = NIL;

        // step 1: a finished slot goes back to the head of the free list
        if (done_hit) begin
            st_n[done_slot] = SLOT_FREE;
            nx_n[done_slot] = free_hn;
            pv_n[done_slot] = NIL;
            free_hn         = {1'b0, done_slot};
        end

        // step 2: urgent head first, normal head otherwise
        if (disp_req) begin
            if (!high_hn[IW]) begin
                found   = 1'b1;
                grab    = ix(high_hn);
                high_hn = nx_n[grab];
                if (high_hn[IW]) high_tn = NIL;
                else             pv_n[ix(high_hn)] = NIL;
            end else if (!norm_hn[IW]) begin
                found   = 1'b1;
                grab    = ix(norm_hn);
                norm_hn = nx_n[grab];
                if (norm_hn[IW]) norm_tn = NIL;
                else             pv_n[ix(norm_hn)] = NIL;
            end
            if (found) begin
                st_n[grab]   = SLOT_RUN;
                core_n[grab] = disp_core;
                nx_n[grab]   = NIL;
                pv_n[grab]   = NIL;
            end
        end

        // step 3: pop the free head and append to the chosen run list
        if (enq_fire) begin
            pop_e         = ix(free_hn);
            free_hn       = nx_n[pop_e];
            desc_n[pop_e] = enq_desc;
            nx_n[pop_e]   = NIL;
            if (enq_urgent) begin
                st_n[pop_e] = SLOT_HIGH;
                pv_n[pop_e] = high_tn;
                if (high_tn[IW]) high_hn = {1'b0, pop_e};
                else             nx_n[ix(high_tn)] = {1'b0, pop_e};
                high_tn = {1'b0, pop_e};
            end else begin
                st_n[pop_e] = SLOT_NORM;
                pv_n[pop_e] = norm_tn;
                if (norm_tn[IW]) norm_hn = {1'b0, pop_e};
                else             nx_n[ix(norm_tn)] = {1'b0, pop_e};
                norm_tn = {1'b0, pop_e};
            end
        end

        // step 4: overdue normal slot under the scan index moves to the urgent tail
        if (st_n[scan] == SLOT_NORM && deadline_hit(desc_n[scan].thresh, now)) begin
            lnk_p = pv_n[scan];
            lnk_q = nx_n[scan];
            if (lnk_p[IW]) norm_hn = lnk_q;
            else           nx_n[ix(lnk_p)] = lnk_q;
            if (lnk_q[IW]) norm_tn = lnk_p;
            else           pv_n[ix(lnk_q)] = lnk_p;
            st_n[scan] = SLOT_HIGH;
            nx_n[scan] = NIL;
            pv_n[scan] = high_tn;
            if (high_tn[IW]) high_hn = {1'b0, scan};
            else             nx_n[ix(high_tn)] = {1'b0, scan};
            high_tn = {1'b0, scan};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) begin
                st_q[i]   <= SLOT_FREE;
                nx_q[i]   <= (i == SLOTS - 1) ? NIL : PW'(i + 1);
                pv_q[i]   <= NIL;
                desc_q[i] <= '0;
                core_q[i] <= '0;
            end
            free_h    <= '0;
            norm_h    <= NIL;
            norm_t    <= NIL;
            high_h    <= NIL;
            high_t    <= NIL;
            rsp_valid <= 1'b0;
            rsp_found <= 1'b0;
            rsp_slot  <= '0;
            rsp_desc  <= '0;
        end else begin
            st_q      <= st_n;
            nx_q      <= nx_n;
            pv_q      <= pv_n;
            desc_q    <= desc_n;
            core_q    <= core_n;
            free_h    <= free_hn;
            norm_h    <= norm_hn;
            norm_t    <= norm_tn;
            high_h    <= high_hn;
            high_t    <= high_tn;
            rsp_valid <= disp_req;
            rsp_found <= found;
            rsp_slot  <= grab;
            rsp_desc  <= found ? desc_q[grab] : '0;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_out
        assign run_mask[g]  = (st_q[g] == SLOT_RUN);
        assign core_tags[g] = core_q[g];
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!free_h[IW] && high_h[IW] && norm_h[IW])); // R1
    AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        disp_req |=> rsp_valid); // R4
    AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (rst)
        (disp_req && !high_h[IW]) |=> (rsp_found && rsp_slot == $past(high_h[IW-1:0]))); // R5
    AST_HEADS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (!high_h[IW] && !norm_h[IW]) |-> (high_h != norm_h)); // R5
    AST_NO_WORK: assert property (@(posedge clk) disable iff (rst)
        (disp_req && high_h[IW] && norm_h[IW]) |=> !rsp_found); // R6
    AST_PROMOTE: assert property (@(posedge clk) disable iff (rst)
        (st_q[scan] == SLOT_NORM && deadline_hit(desc_q[scan].thresh, now)
         && !(disp_req && high_h[IW] && norm_h == {1'b0, scan}))
        |=> st_q[$past(scan)] == SLOT_HIGH); // R7
    AST_CORE_RECORDED: assert property (@(posedge clk) disable iff (rst)
        rsp_found |-> (st_q[rsp_slot] == SLOT_RUN && core_q[rsp_slot] == $past(disp_core))); // R9
    AST_FULL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (enq_valid && !enq_ready && !done_hit) |=> !enq_ready); // R3

endmodule

// File: rtl/rtsched_top.sv
module rtsched_top
    import rtsched_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      enq_valid,
    output logic                      enq_ready,
    input  logic [PID_W-1:0]          enq_pid,
    input  logic [TID_W-1:0]          enq_tid,
    input  logic [CTX_W-1:0]          enq_ctx,
    input  logic [TIME_W-1:0]         enq_thresh,
    input  logic                      enq_urgent,
    input  logic                      disp_req,
    input  logic [CORE_W-1:0]         disp_core,
    output logic                      disp_valid,
    output logic                      disp_found,
    output logic [$clog2(SLOTS)-1:0]  disp_slot,
    output logic [PID_W-1:0]          disp_pid,
    output logic [TID_W-1:0]          disp_tid,
    output logic [CTX_W-1:0]          disp_ctx,
    input  logic                      done_valid,
    input  logic [CORE_W-1:0]         done_core,
    output logic [TIME_W-1:0]         cycle_now
);
    localparam int IW = $clog2(SLOTS);

    logic [IW-1:0]                scan;
    logic [SLOTS-1:0]             run_mask;
    logic [SLOTS-1:0][CORE_W-1:0] core_tags;
    logic                         done_hit;
    logic [IW-1:0]                done_slot;
    thread_desc_t                 enq_desc;
    thread_desc_t                 rsp_desc;

    assign enq_desc = '{pid: enq_pid, tid: enq_tid, ctx: enq_ctx, thresh: enq_thresh};

    rtsched_timebase #(.SLOTS(SLOTS)) u_time (
        .clk  (clk),
        .rst  (rst),
        .now  (cycle_now),
        .scan (scan)
    );

    rtsched_core_match #(.SLOTS(SLOTS)) u_match (
        .run_mask   (run_mask),
        .core_tags  (core_tags),
        .done_valid (done_valid),
        .done_core  (done_core),
        .hit        (done_hit),
        .hit_slot   (done_slot)
    );

    rtsched_list_table #(.SLOTS(SLOTS)) u_table (
        .clk        (clk),
        .rst        (rst),
        .now        (cycle_now),
        .scan       (scan),
        .done_hit   (done_hit),
        .done_slot  (done_slot),
        .enq_valid  (enq_valid),
        .enq_urgent (enq_urgent),
        .enq_desc   (enq_desc),
        .enq_ready  (enq_ready),
        .disp_req   (disp_req),
        .disp_core  (disp_core),
        .run_mask   (run_mask),
        .core_tags  (core_tags),
        .rsp_valid  (disp_valid),
        .rsp_found  (disp_found),
        .rsp_slot   (disp_slot),
        .rsp_desc   (rsp_desc)
    );

    assign disp_pid = rsp_desc.pid;
    assign disp_tid = rsp_desc.tid;
    assign disp_ctx = rsp_desc.ctx;

endmodule

// File: tb/tb_rtsched_top.sv
`timescale 1ns/1ps
module tb_rtsched_top;

    localparam int NS     = 16;
    localparam int NCORE  = 8;
    localparam int CYCLES = 4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enq_valid = 1'b0, enq_urgent = 1'b0;
    logic        enq_ready;
    logic [7:0]  enq_pid = '0, enq_tid = '0;
    logic [15:0] enq_ctx = '0, enq_thresh = '0;
    logic        disp_req = 1'b0;
    logic [2:0]  disp_core = '0;
    logic        disp_valid, disp_found;
    logic [3:0]  disp_slot;
    logic [7:0]  disp_pid, disp_tid;
    logic [15:0] disp_ctx;
    logic        done_valid = 1'b0;
    logic [2:0]  done_core = '0;
    logic [15:0] cycle_now;

    always #2.5 clk = ~clk;

    rtsched_top dut (
        .clk(clk), .rst(rst),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_pid(enq_pid), .enq_tid(enq_tid), .enq_ctx(enq_ctx),
        .enq_thresh(enq_thresh), .enq_urgent(enq_urgent),
        .disp_req(disp_req), .disp_core(disp_core),
        .disp_valid(disp_valid), .disp_found(disp_found), .disp_slot(disp_slot),
        .disp_pid(disp_pid), .disp_tid(disp_tid), .disp_ctx(disp_ctx),
        .done_valid(done_valid), .done_core(done_core),
        .cycle_now(cycle_now)
    );

    // reference state: 0 free, 1 normal, 2 urgent, 3 running
    int          mst [NS];
    int          mcore [NS];
    logic [7:0]  mpid [NS], mtid [NS];
    logic [15:0] mctx [NS], mth [NS];
    int          free_q[$], norm_q[$], high_q[$];
    logic [15:0] mnow;

    bit          exp_valid, exp_found;
    int          exp_slot;
    logic [7:0]  exp_pid, exp_tid;
    logic [15:0] exp_ctx;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic bit core_busy(input int c);
        for (int i = 0; i < NS; i++)
            if (mst[i] == 3 && mcore[i] == c) return 1'b1;
        return 1'b0;
    endfunction

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1234);
        for (int i = 0; i < NS; i++) begin
            mst[i] = 0; mcore[i] = 0; mpid[i] = '0; mtid[i] = '0; mctx[i] = '0; mth[i] = '0;
            free_q.push_back(i);
        end
        mnow = '0;
        exp_valid = 1'b0; exp_found = 1'b0; exp_slot = 0;
        exp_pid = '0; exp_tid = '0; exp_ctx = '0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        for (int cyc = 0; cyc < CYCLES; cyc++) begin
            bit          dv, rq, ev, eu, rdy;
            int          dc, rc, grab, sc;
            logic [15:0] th;
            logic [7:0]  p, t;
            logic [15:0] cx;
            if (cyc > 0) @(negedge clk);

            // ---- compare outputs against the reference left by the last edge
            if (cyc == 0) begin
                chk("R1 cycle_now after reset", 32'(cycle_now), 32'd0);
                chk("R1 enq_ready after reset", 32'(enq_ready), 32'd1);
                chk("R1 disp_valid after reset", 32'(disp_valid), 32'd0);
            end else begin
                chk("R10 cycle_now", 32'(cycle_now), 32'(mnow));
            end
            rdy = (free_q.size() > 0);
            chk("R3 R8 R9 enq_ready", 32'(enq_ready), 32'(rdy));
            chk("R4 disp_valid", 32'(disp_valid), 32'(exp_valid));
            if (exp_valid) begin
                chk("R6 disp_found", 32'(disp_found), 32'(exp_found));
                if (exp_found) begin
                    chk("R2 R5 R7 R8 R11 disp_slot", 32'(disp_slot), 32'(exp_slot));
                    chk("R4 disp_pid", 32'(disp_pid), 32'(exp_pid));
                    chk("R4 disp_tid", 32'(disp_tid), 32'(exp_tid));
                    chk("R4 disp_ctx", 32'(disp_ctx), 32'(exp_ctx));
                end
            end

            // ---- choose stimulus
            dv = 1'b0; dc = 0; rq = 1'b0; rc = 0; ev = 1'b0; eu = 1'b0; th = '0;
            p = 8'($urandom); t = 8'($urandom); cx = 16'($urandom);
            if (cyc < 4) begin
                rq = 1'b1; rc = cyc;                       // R6: lists empty
            end else if (cyc < 40) begin
                ev = 1'b1; eu = ($urandom % 3) == 0;       // R3: fill the table
                th = mnow + 16'd30000;
            end else begin
                ev = ($urandom % 3) != 0;
                eu = ($urandom % 5) == 0;
                if (($urandom % 4) == 0) th = mnow - 16'($urandom % 8);
                else                     th = mnow + 16'($urandom % 64);
                rc = $urandom % NCORE;
                rq = !core_busy(rc) && (($urandom % 2) == 0);
                dc = $urandom % NCORE;
                dv = core_busy(dc) ? (($urandom % 4) == 0) : (($urandom % 12) == 0);
            end
            enq_valid = ev; enq_urgent = eu; enq_pid = p; enq_tid = t;
            enq_ctx = cx; enq_thresh = th;
            disp_req = rq; disp_core = 3'(rc);
            done_valid = dv; done_core = 3'(dc);

            // ---- advance reference one cycle: completion, dispatch, enqueue, promotion (R11)
            if (dv) begin                                   // R8
                for (int i = 0; i < NS; i++) begin
                    if (mst[i] == 3 && mcore[i] == dc) begin
                        mst[i] = 0;
                        free_q.push_front(i);
                        break;
                    end
                end
            end
            exp_valid = rq; exp_found = 1'b0;
            if (rq) begin                                   // R5
                grab = -1;
                if (high_q.size() > 0)      grab = high_q.pop_front();
                else if (norm_q.size() > 0) grab = norm_q.pop_front();
                if (grab >= 0) begin
                    exp_found = 1'b1; exp_slot = grab;
                    exp_pid = mpid[grab]; exp_tid = mtid[grab]; exp_ctx = mctx[grab];
                    mst[grab] = 3; mcore[grab] = rc;        // R9
                end
            end
            if (ev && rdy) begin                            // R2
                grab = free_q.pop_front();
                mpid[grab] = p; mtid[grab] = t; mctx[grab] = cx; mth[grab] = th;
                if (eu) begin mst[grab] = 2; high_q.push_back(grab); end
                else    begin mst[grab] = 1; norm_q.push_back(grab); end
            end
            sc = int'(mnow % 16);                            // R7
            if (mst[sc] == 1 && mth[sc] <= mnow) begin
                foreach (norm_q[k]) begin
                    if (norm_q[k] == sc) begin
                        norm_q.delete(k);
                        break;
                    end
                end
                mst[sc] = 2;
                high_q.push_back(sc);
            end
            mnow = mnow + 16'd1;
        end

        @(negedge clk);
        chk("R4 final disp_valid", 32'(disp_valid), 32'(exp_valid));
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #1ms;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1..: run did not complete");
            summary();
            $finish;
        end
    end

endmodule